// File: doc/BRIEF.md
# Serial Clock Prescaler

This block turns a fast system clock into the serial clock for a synchronous serial shifter. It reads a mode word and uses two fields from it: a 4-bit prescale value PM at bits 19:16 and a divide-by-16 enable at bit 27. The output clock period is 4×(PM+1) input cycles, or 64×(PM+1) when the divide-by-16 enable is set. The slowest setting is therefore 1024 cycles per serial clock period. Bit 29 of the mode word sets the idle level of the serial clock.

The shifter pulses `frame_start` to begin a frame and `frame_stop` to end it. A start clears both counter stages and captures the three configuration fields. The block then toggles `sck` at a 50% duty cycle. At each toggle it raises either `lead_stb` (the clock leaves its idle level) or `trail_stb` (the clock returns to idle) for exactly one cycle. The shifter can use these strobes to time its sampling and shifting. Between frames, `sck` rests at the idle level and follows bit 29 of the mode word with one cycle of delay.

Top module: `sck_prescaler`

## Requirements
- R1: After reset `sck` is 0 and both strobes are low, and they stay that way until a start while the mode word is zero.
- R2: With bit 27 of the mode word clear, each `sck` half period is 2×(PM+1) cycles, where PM is mode bits 19:16. The full period is 4×(PM+1) cycles with equal high and low times.
- R3: With bit 27 set, each `sck` half period is 32×(PM+1) cycles.
- R4: With bit 27 set and PM = 15, the `sck` period is 1024 cycles.
- R5: The idle level of `sck` is bit 29 of the mode word. While no frame runs, `sck` equals that bit one cycle after the bit is presented. A leading edge always drives `sck` to the level opposite the captured idle level.
- R6: `lead_stb` and `trail_stb` are each high for one cycle, in the same cycle that `sck` first shows its new level. The first strobe of a frame is a leading one, then the two alternate, and they are never high together.
- R7: If `frame_start` is sampled at a clock edge, `sck` is at the idle level after that edge. The first leading edge appears exactly one half period later. A start during a running frame restarts the timing in the same way.
- R8: Changes to mode bits 19:16, 27 and 29 while a frame runs do not alter `sck` or the strobes of that frame. They take effect at the next start.
- R9: If `frame_stop` is sampled at a clock edge without `frame_start`, `sck` is at the idle level after that edge. No strobe is raised until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that feeds the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 32 | Mode word: PM at 19:16, divide-by-16 enable at 27, idle level at 29 |
| frame_start | input | 1 | One-cycle pulse that begins a frame and captures the configuration |
| frame_stop | input | 1 | One-cycle pulse that ends the frame |
| sck | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe when `sck` leaves its idle level |
| trail_stb | output | 1 | One-cycle strobe when `sck` returns to its idle level |

## Verification
The assertions check several properties on every cycle:
- the half-period counter never passes the limit set by the captured prescale value;
- the captured configuration stays frozen while a frame runs;
- the two strobes never coincide, and a leading strobe is never followed directly by another strobe;
- every leading strobe comes with `sck` away from its idle level;
- a stop is never accompanied by a strobe.

Only the bench scenarios can show the exact number of cycles from start to each edge for each prescale and divider setting. They also show the 1024-cycle extreme, that a mid-frame mode change is ignored while it is then used at the next start, and that the idle level follows the mode word between frames.

// File: rtl/sckpre_pkg.sv
package sckpre_pkg;

   // Edge event produced at a serial clock toggle
   typedef enum logic [1:0] {
      EDGE_NONE  = 2'd0,
      EDGE_LEAD  = 2'd1,
      EDGE_TRAIL = 2'd2
   } edge_e;

   // Default field placement inside the mode word
   localparam int unsigned SCKPRE_MODE_W    = 32;
   localparam int unsigned SCKPRE_PM_W      = 4;
   localparam int unsigned SCKPRE_PM_LSB    = 16;
   localparam int unsigned SCKPRE_DIV_BIT   = 27;
   localparam int unsigned SCKPRE_CPOL_BIT  = 29;
   localparam int unsigned SCKPRE_PRE_DIV   = 16;
   localparam int unsigned SCKPRE_HALF_MULT = 2;

endpackage

// File: rtl/sckpre_ctrl.sv
module sckpre_ctrl #(
   parameter int unsigned PM_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            stop_i,
   input  logic [PM_W-1:0] pm_i,
   input  logic            div_i,
   input  logic            cpol_i,
   output logic            run_o,
   output logic            live_o,
   output logic [PM_W-1:0] pm_o,
   output logic            div_o,
   output logic            cpol_o
);

   logic            run_q;
   logic [PM_W-1:0] pm_q;
   logic            div_q;
   logic            cpol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pm_q   <= '0;
         div_q  <= 1'b0;
         cpol_q <= 1'b0;
      end else if (start_i) begin
         run_q  <= 1'b1;
         pm_q   <= pm_i;
         div_q  <= div_i;
         cpol_q <= cpol_i;
      end else if (stop_i) begin
         run_q  <= 1'b0;
      end
   end

   assign run_o  = run_q;
   assign live_o = run_q && !start_i && !stop_i;
   assign pm_o   = pm_q;
   assign div_o  = div_q;
   assign cpol_o = cpol_q;

   // R8: captured configuration frozen while a frame runs
   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start_i) |=> ($stable(pm_q) && $stable(div_q) && $stable(cpol_q)));

endmodule

// File: rtl/sckpre_prediv.sv
module sckpre_prediv #(
   parameter int unsigned PRE_DIV = 16,
   localparam int unsigned PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic live_i,
   input  logic div_en_i,
   output logic tick_o
);

   if ((PRE_DIV & (PRE_DIV - 1)) != 0) begin : g_bad_prediv
      $error("sckpre_prediv: PRE_DIV must be a power of two");
   end

   if (PRE_DIV == 1) begin : g_no_prediv
      assign tick_o = live_i;
   end else begin : g_prediv
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk) begin
         if (!rst_n || !live_i) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      assign tick_o = live_i && (!div_en_i || (pre_q == PRE_W'(PRE_DIV - 1)));

      // R3: the pre-divider rests at zero whenever no frame is counting
      assert_pre_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !live_i |=> (pre_q == '0));
   end

endmodule

// File: rtl/sckpre_halfcnt.sv
module sckpre_halfcnt #(
   parameter int unsigned PM_W      = 4,
   parameter int unsigned HALF_MULT = 2,
   localparam int unsigned HALF_MAX = HALF_MULT * (2 ** PM_W),
   localparam int unsigned CNT_W    = $clog2(HALF_MAX)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            live_i,
   input  logic            tick_i,
   input  logic [PM_W-1:0] pm_i,
   output logic            toggle_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   span;
   logic [CNT_W:0]   lim;
   logic             at_lim;

   assign span   = (CNT_W+1)'(HALF_MULT) * ((CNT_W+1)'(pm_i) + (CNT_W+1)'(1));
   assign lim    = span - (CNT_W+1)'(1);
   assign at_lim = ({1'b0, cnt_q} == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !live_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (at_lim) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign toggle_o = tick_i && at_lim;

   // R2: the half-period counter never passes the captured limit
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt_q} <= lim);

endmodule

// File: rtl/sckpre_edge_gen.sv
module sckpre_edge_gen
   import sckpre_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic live_i,
   input  logic toggle_i,
   input  logic cpol_i,
   input  logic idle_i,
   output logic sck_o,
   output logic lead_o,
   output logic trail_o
);

   logic  sck_q;
   edge_e ev_q;
   edge_e ev_d;

   always_comb begin
      if (!toggle_i) begin
         ev_d = EDGE_NONE;
      end else if (sck_q == cpol_i) begin
         ev_d = EDGE_LEAD;
      end else begin
         ev_d = EDGE_TRAIL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         ev_q  <= EDGE_NONE;
      end else if (!live_i) begin
         sck_q <= idle_i;
         ev_q  <= EDGE_NONE;
      end else begin
         if (toggle_i) begin
            sck_q <= ~sck_q;
         end
         ev_q <= ev_d;
      end
   end

   assign sck_o   = sck_q;
   assign lead_o  = (ev_q == EDGE_LEAD);
   assign trail_o = (ev_q == EDGE_TRAIL);

   // R6: strobes never coincide
   assert_edge_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_o && trail_o));

   // R6: a leading strobe is one cycle wide and never directly followed by another strobe
   assert_lead_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lead_o |=> (!lead_o && !trail_o));

endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
   import sckpre_pkg::*;
#(
   parameter int unsigned MODE_W    = SCKPRE_MODE_W,
   parameter int unsigned PM_W      = SCKPRE_PM_W,
   parameter int unsigned PM_LSB    = SCKPRE_PM_LSB,
   parameter int unsigned DIV_BIT   = SCKPRE_DIV_BIT,
   parameter int unsigned CPOL_BIT  = SCKPRE_CPOL_BIT,
   parameter int unsigned PRE_DIV   = SCKPRE_PRE_DIV,
   parameter int unsigned HALF_MULT = SCKPRE_HALF_MULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              frame_start,
   input  logic              frame_stop,
   output logic              sck,
   output logic              lead_stb,
   output logic              trail_stb
);

   if (PM_LSB + PM_W > MODE_W) begin : g_bad_pm
      $error("sck_prescaler: prescale field exceeds mode word");
   end
   if (DIV_BIT >= MODE_W || CPOL_BIT >= MODE_W) begin : g_bad_bits
      $error("sck_prescaler: control bit outside mode word");
   end
   if (HALF_MULT < 2) begin : g_bad_mult
      $error("sck_prescaler: HALF_MULT below 2 breaks strobe alternation");
   end

   logic [PM_W-1:0] pm_live;
   logic            div_live;
   logic            cpol_live;
   logic [PM_W-1:0] pm_q;
   logic            div_q;
   logic            cpol_q;
   logic            run_q;
   logic            live;
   logic            tick;
   logic            toggle;

   assign pm_live   = mode_word[PM_LSB +: PM_W];
   assign div_live  = mode_word[DIV_BIT];
   assign cpol_live = mode_word[CPOL_BIT];

   sckpre_ctrl #(.PM_W(PM_W)) i_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(frame_start),
      .stop_i (frame_stop),
      .pm_i   (pm_live),
      .div_i  (div_live),
      .cpol_i (cpol_live),
      .run_o  (run_q),
      .live_o (live),
      .pm_o   (pm_q),
      .div_o  (div_q),
      .cpol_o (cpol_q)
   );

   sckpre_prediv #(.PRE_DIV(PRE_DIV)) i_prediv (
      .clk     (clk),
      .rst_n   (rst_n),
      .live_i  (live),
      .div_en_i(div_q),
      .tick_o  (tick)
   );

   sckpre_halfcnt #(.PM_W(PM_W), .HALF_MULT(HALF_MULT)) i_halfcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .live_i  (live),
      .tick_i  (tick),
      .pm_i    (pm_q),
      .toggle_o(toggle)
   );

   sckpre_edge_gen i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .live_i  (live),
      .toggle_i(toggle),
      .cpol_i  (cpol_q),
      .idle_i  (cpol_live),
      .sck_o   (sck),
      .lead_o  (lead_stb),
      .trail_o (trail_stb)
   );

   // R5: a leading strobe always shows the clock away from its captured idle level
   assert_lead_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sck != cpol_q));

   // R9: ending a frame never produces a strobe
   assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> (!lead_stb && !trail_stb));

endmodule

// File: tb/test_sck_prescaler.sv
`timescale 1ns/1ps
module test_sck_prescaler;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mode_word = '0;
   logic        frame_start = 1'b0;
   logic        frame_stop = 1'b0;
   logic        sck;
   logic        lead_stb;
   logic        trail_stb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sck_prescaler i_sck_prescaler (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_word  (mode_word),
      .frame_start(frame_start),
      .frame_stop (frame_stop),
      .sck        (sck),
      .lead_stb   (lead_stb),
      .trail_stb  (trail_stb)
   );

   function automatic logic [31:0] mk_mode(int pm, bit d16, bit cp);
      logic [31:0] m;
      m = '0;
      m[19:16] = pm[3:0];
      m[27]    = d16;
      m[29]    = cp;
      return m;
   endfunction

   function automatic int half_of(int pm, bit d16);
      return 2 * (pm + 1) * (d16 ? 16 : 1);
   endfunction

   function automatic bit exp_sck(int n, int h, bit cp);
      if (n == 0) return cp;
      return cp ^ bit'((n / h) % 2);
   endfunction

   function automatic bit exp_lead(int n, int h);
      return (n > 0) && (n % h == 0) && ((n / h) % 2 == 1);
   endfunction

   function automatic bit exp_trail(int n, int h);
      return (n > 0) && (n % h == 0) && ((n / h) % 2 == 0);
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // called at a negedge; returns at a negedge
   task automatic run_frame(string req, int pm, bit d16, bit cp, int ncyc,
                            int chg_at, logic [31:0] chg_mode);
      int h;
      string tag;
      h = half_of(pm, d16);
      mode_word   = mk_mode(pm, d16, cp);
      frame_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      frame_start = 1'b0;
      chk("R7", "sck at start", sck, cp);
      chk("R7", "lead at start", lead_stb, 1'b0);
      chk("R7", "trail at start", trail_stb, 1'b0);
      for (int n = 1; n <= ncyc; n++) begin
         @(negedge clk);
         tag = (chg_at >= 0 && n > chg_at) ? "R8" : ((n <= h) ? "R7" : req);
         chk(tag, "sck", sck, exp_sck(n, h, cp));
         chk((chg_at >= 0 && n > chg_at) ? "R8" : "R6", "lead_stb", lead_stb, exp_lead(n, h));
         chk((chg_at >= 0 && n > chg_at) ? "R8" : "R6", "trail_stb", trail_stb, exp_trail(n, h));
         if (n == chg_at) mode_word = chg_mode;
      end
   endtask

   task automatic stop_frame();
      frame_stop = 1'b1;
      @(posedge clk);
      @(negedge clk);
      frame_stop = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R9", "sck idle after stop", sck, mode_word[29]);
         chk("R9", "lead after stop", lead_stb, 1'b0);
         chk("R9", "trail after stop", trail_stb, 1'b0);
         @(negedge clk);
      end
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd7321);
      repeat (3) @(negedge clk);
      chk("R1", "sck in reset", sck, 1'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "sck after reset", sck, 1'b0);
      chk("R1", "lead after reset", lead_stb, 1'b0);
      chk("R1", "trail after reset", trail_stb, 1'b0);

      // idle level follows bit 29 between frames
      mode_word = mk_mode(0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R5", "idle follows polarity high", sck, 1'b1);
      mode_word = mk_mode(0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R5", "idle follows polarity low", sck, 1'b0);

      // fastest ratio, 4 cycles per period
      run_frame("R2", 0, 1'b0, 1'b0, 12, -1, '0);
      stop_frame();
      // PM=3, idle high
      run_frame("R2", 3, 1'b0, 1'b1, 40, -1, '0);
      stop_frame();
      // pre-divider with PM=0
      run_frame("R3", 0, 1'b1, 1'b0, 100, -1, '0);
      stop_frame();
      // slowest ratio, 1024 cycles per period
      run_frame("R4", 15, 1'b1, 1'b0, 2050, -1, '0);
      stop_frame();
      // restart mid-frame without stop
      run_frame("R7", 2, 1'b0, 1'b0, 9, -1, '0);
      run_frame("R7", 5, 1'b0, 1'b1, 30, -1, '0);
      stop_frame();
      // mid-frame configuration change is ignored
      run_frame("R8", 1, 1'b0, 1'b0, 40, 5, mk_mode(9, 1'b1, 1'b1));
      stop_frame();
      // the changed configuration is used at the next start
      run_frame("R8", 9, 1'b1, 1'b1, 660, -1, '0);
      stop_frame();

      for (int i = 0; i < 12; i++) begin
         int pm;
         bit d16;
         bit cp;
         int nc;
         pm  = int'($urandom % 16);
         d16 = ($urandom % 4) == 0;
         cp  = bit'($urandom % 2);
         nc  = 2 * half_of(pm, d16) + int'($urandom % 5) + 1;
         run_frame(d16 ? "R3" : "R2", pm, d16, cp, nc, -1, '0);
         if ($urandom % 3 != 0) stop_frame();
      end
      stop_frame();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule